// File: doc/BRIEF.md
# Breakpoint Tag and Acknowledge Controller

This controller sits next to a short instruction pipeline. It watches an active-low hardware breakpoint pin. It samples that pin only on a clock edge where fetched read data is valid, and it attaches a tag to the word being captured. The tag follows the data rather than an address.

The type of fetch decides when the tag is released:
- A prefetched opcode word carries its tag down a shift register, one bit per pipeline stage. The tag is released when that word is the instruction that completes.
- An operand word tags the instruction currently executing. That tag is released when this instruction completes.

A pipe flush discards every tag still held, so a pin pulse that is too short can be lost.

On release, the controller does one of two things:
- With background debug disabled, it raises a breakpoint acknowledge request and holds it until the bus reports the cycle done. It drives the CPU-space function code and address for that cycle.
- With background debug enabled, it gives a one-cycle debug-entry pulse instead.

While an acknowledge is outstanding, the pin is not sampled.

Top module: `bkpt_tag_ctrl`

## Requirements
- R1: The breakpoint pin (`bkpt_n`, active low) is sampled only on a rising edge where `fetch_valid` is 1. A low pin without valid data creates no tag.
- R2: A breakpoint sampled with a prefetch (`fetch_is_op`=0) travels with its word.
  - Each prefetch shifts the pipeline by one stage.
  - The word reaches the execute stage after STAGES-1 further prefetches.
  - `ack_req` rises the cycle after the first `insn_done` seen while the word is in the execute stage.
  - An `insn_done` before that point does not trigger.
- R3: A breakpoint sampled with an operand fetch (`fetch_is_op`=1) triggers after the next `insn_done`. An operand fetch in the same cycle as `insn_done` belongs to the following instruction.
- R4: `flush` clears every held tag. A sample taken in the same cycle as `flush` is dropped.
- R5: `ack_req` stays 1 until a cycle with `bus_done`=1, and it is 0 from the following cycle.
- R6: While `ack_req` is 1, the breakpoint pin is ignored and no tag is created.
- R7: If `bdm_en` is 1 at release, `dbg_enter` pulses for exactly one cycle and `ack_req` stays 0.
- R8: While `ack_req` is 1, the CPU-space outputs are driven as follows. When idle, both `cpu_fc` and `cpu_addr` are zero, so type 3 and type F never appear.

| Output bits | Value while `ack_req` is 1 |
|---|---|
| `cpu_fc` | 3'b111 |
| `cpu_addr[19:16]` | 4'h0 (type 0) |
| `cpu_addr[4:2]` | breakpoint number 0 |
| all other `cpu_addr` bits | 0 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bkpt_n | input | 1 | Hardware breakpoint request, active low |
| fetch_valid | input | 1 | Read data is captured this edge |
| fetch_is_op | input | 1 | 1 for operand fetch, 0 for prefetch |
| insn_done | input | 1 | Executing instruction completes this edge |
| flush | input | 1 | Pipe flush, discards all tags |
| bdm_en | input | 1 | Background debug enabled |
| bus_done | input | 1 | Acknowledge bus cycle complete |
| ack_req | output | 1 | Breakpoint acknowledge cycle requested |
| dbg_enter | output | 1 | One-cycle debug entry pulse |
| cpu_addr | output | 24 | Address for the CPU-space cycle |
| cpu_fc | output | 3 | Function code for the CPU-space cycle |

## Verification
Every result is registered once, so the result of a stimulus is due one cycle after the edge that sees it:
- `ack_req` and `dbg_enter` follow the edge carrying the releasing `insn_done`.
- `ack_req` falls the cycle after `bus_done`.
- `cpu_addr` and `cpu_fc` follow `ack_req` combinationally.

The bench drives each vector on the falling edge and samples one time unit after the next rising edge, so each expectation covers exactly one clock. Prefetch tags are counted through STAGES-1 further prefetches before the releasing `insn_done` is applied.

// File: rtl/bkpt_tag_ctrl.sv
module bkpt_tag_ctrl #(
  parameter int STAGES  = 3,
  parameter int ADDR_W  = 24,
  parameter int FC_W    = 3,
  parameter int BKPT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkpt_n,
  input  logic              fetch_valid,
  input  logic              fetch_is_op,
  input  logic              insn_done,
  input  logic              flush,
  input  logic              bdm_en,
  input  logic              bus_done,
  output logic              ack_req,
  output logic              dbg_enter,
  output logic [ADDR_W-1:0] cpu_addr,
  output logic [FC_W-1:0]   cpu_fc
);
  localparam int LAST = STAGES - 1;
  localparam logic [3:0] TYPE_BKPT = 4'h0;
  localparam logic [ADDR_W-1:0] ACK_ADDR =
    (ADDR_W'(TYPE_BKPT) << 16) | (ADDR_W'(BKPT_ID) << 2);

  logic [STAGES-1:0] tag, tag_nx;
  logic              op_tag, op_nx;
  logic              hit, shift, retire, fire;

  assign hit    = ~bkpt_n & fetch_valid & ~ack_req;
  assign shift  = fetch_valid & ~fetch_is_op;
  assign retire = insn_done & ~ack_req;
  assign fire   = retire & (tag[LAST] | op_tag);

  always_comb begin
    tag_nx = tag;
    op_nx  = op_tag;
    if (retire) begin
      tag_nx[LAST] = 1'b0;
      op_nx        = 1'b0;
    end
    if (shift) tag_nx = {tag_nx[LAST-1:0], hit};
    if (hit & fetch_is_op) op_nx = 1'b1;
    if (flush) begin
      tag_nx = '0;
      op_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag       <= '0;
      op_tag    <= 1'b0;
      ack_req   <= 1'b0;
      dbg_enter <= 1'b0;
    end else begin
      tag       <= tag_nx;
      op_tag    <= op_nx;
      dbg_enter <= fire & bdm_en;
      if (fire)          ack_req <= ~bdm_en;
      else if (bus_done) ack_req <= 1'b0;
    end
  end

  assign cpu_fc   = ack_req ? '1 : '0;
  assign cpu_addr = ack_req ? ACK_ADDR : '0;

  assert_ack_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !bus_done) |=> ack_req);

  assert_ack_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(insn_done));

  assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tag == '0 && !op_tag));

  assert_dbg_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |-> !ack_req);

  assert_busy_no_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && fetch_is_op && !insn_done && !flush) |=> (op_tag == $past(op_tag)));
endmodule

// File: tb/bkpt_tag_ctrl_bench.sv
module bkpt_tag_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  // vector bits: {bkpt_n, fetch_valid, fetch_is_op, insn_done, flush, bdm_en, bus_done, exp_ack, exp_dbg}
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b0100000_00, 9'b1100000_00, 9'b1001000_00, 9'b1100000_00, 9'b1001000_10,
    9'b1000000_10, 9'b0110000_10, 9'b1000001_00, 9'b1001000_00, 9'b0110000_00,
    9'b1001000_10, 9'b1000001_00, 9'b0010000_00, 9'b1001000_00, 9'b0110100_00,
    9'b1001000_00, 9'b0100000_00, 9'b1000100_00, 9'b1100000_00, 9'b1100000_00,
    9'b1001000_00, 9'b0110010_00, 9'b1001010_01, 9'b1000000_00, 9'b0111000_00,
    9'b1001000_10, 9'b1000001_00
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bkpt_n = 1'b1, fetch_valid = 1'b0, fetch_is_op = 1'b0, insn_done = 1'b0;
  logic flush = 1'b0, bdm_en = 1'b0, bus_done = 1'b0;
  logic ack_req, dbg_enter;
  logic [23:0] cpu_addr;
  logic [2:0] cpu_fc;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_tag_ctrl u_bkpt_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .bkpt_n(bkpt_n), .fetch_valid(fetch_valid),
    .fetch_is_op(fetch_is_op), .insn_done(insn_done), .flush(flush),
    .bdm_en(bdm_en), .bus_done(bus_done), .ack_req(ack_req),
    .dbg_enter(dbg_enter), .cpu_addr(cpu_addr), .cpu_fc(cpu_fc)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int i);
    case (i)
      0, 12, 13:              return "R1";
      1, 2, 3, 4:             return "R2";
      9, 10, 24, 25:          return "R3";
      14, 15, 16, 17, 18, 19, 20: return "R4";
      5, 7, 11, 26:           return "R5";
      6, 8:                   return "R6";
      default:                return "R7";
    endcase
  endfunction

  task automatic drive(logic [6:0] v);
    @(negedge clk);
    {bkpt_n, fetch_valid, fetch_is_op, insn_done, flush, bdm_en, bus_done} = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", "reset ack_req", 32'(ack_req), 0);
    check("R8", "reset dbg_enter", 32'(dbg_enter), 0);
    check("R8", "reset cpu_addr", 32'(cpu_addr), 0);
    check("R8", "reset cpu_fc", 32'(cpu_fc), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8:2]);
      check(req_of(i), $sformatf("vec %0d ack_req", i), 32'(ack_req), 32'(VEC[i][1]));
      check(req_of(i), $sformatf("vec %0d dbg_enter", i), 32'(dbg_enter), 32'(VEC[i][0]));
      check("R8", $sformatf("vec %0d cpu_fc", i), 32'(cpu_fc), VEC[i][1] ? 32'h7 : 32'h0);
    end

    // R8: CPU-space fields during an acknowledge
    drive(7'b0110000);
    drive(7'b1001000);
    check("R8", "ack cpu_fc", 32'(cpu_fc), 32'h7);
    check("R8", "ack type field", 32'(cpu_addr[19:16]), 32'h0);
    check("R8", "ack cpu_addr", 32'(cpu_addr), 32'h0);
    check("R5", "ack held", 32'(ack_req), 1);
    drive(7'b1000001);
    check("R5", "ack cleared", 32'(ack_req), 0);

    // R2: prefetch released at insn_done coinciding with the shifting prefetch
    drive(7'b0100000);
    drive(7'b1100000);
    drive(7'b1100000);
    drive(7'b1101000);
    check("R2", "pf release with shift", 32'(ack_req), 1);
    drive(7'b1000001);
    check("R5", "ack cleared again", 32'(ack_req), 0);

    // R6: pin ignored during acknowledge for prefetches too
    drive(7'b0110000);
    drive(7'b1001000);
    drive(7'b0100000);
    drive(7'b1100000);
    drive(7'b1100000);
    drive(7'b1000001);
    drive(7'b1001000);
    check("R6", "no tag from busy prefetch", 32'(ack_req), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule